// File: doc/BRIEF.md
# USB FIFO Parallel Bus Bridge

This block connects an on-chip byte requester to an external USB FIFO device that has an asynchronous 8-bit parallel interface. On the device side there is one byte bus that reads and writes share, an active-low read strobe, an active-low write strobe, and two active-low status flags. One flag means "received data waiting". The other means "room to transmit". The bus is split into an output value, an output enable and an input value, so that the pad ring can build the tristate buffer.

On the user side the requester sees three things. The first is a busy signal in the style of a wait-request. The second is a one-cycle read-data-valid pulse that comes with the captured byte. The third is the two device flags, synchronised and made active high, so the requester can check them before it asks. A request is a single-cycle pulse presented while the block is idle. Every strobe width, setup, hold and recovery interval is counted in system-clock cycles. With a 50 MHz clock, 3 strobe cycles give 60 ns and meet a 50 ns minimum pulse.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While `rst_n` is low, `busy` and `rd_valid` are 0, both strobes are 1, and `pad_oe` is 0.
- R2: `tx_room` is the inverse of `chip_tx_n` and `rx_avail` is the inverse of `chip_rx_n`. Each is delayed by exactly 2 clock edges.
- R3: A write is accepted at a clock edge only when the block is idle, `req_wr` is 1 and `tx_room` is 1. `busy` is 1 from the next cycle until the transaction ends, and then returns to 0.
- R4: A write drives `pad_oe` with the byte latched at acceptance for SETUP_CYC cycles with `wr_strobe_n` high. Then `wr_strobe_n` is 0 for STROBE_CYC cycles. Then the byte stays driven for HOLD_CYC cycles with the strobe high, and after that `pad_oe` falls.
- R5: A read holds `rd_strobe_n` at 0 for STROBE_CYC cycles starting the cycle after acceptance. `pad_oe` stays 0 throughout the read. `rd_byte` takes the value of `pad_din` in the last strobe-low cycle only.
- R6: After a read, `rd_valid` is 1 for exactly one cycle: the first cycle in which `busy` is 0. `rd_byte` holds the captured byte in that cycle.
- R7: Every transaction ends with GAP_CYC cycles (at least 2) in which both strobes are high, `pad_oe` is 0 and `busy` is still 1.
- R8: When `req_wr` and `req_rd` are both 1 at an idle edge and both flags allow, the write is performed and the read request is dropped.
- R9: A request is ignored, with no strobe, no bus drive and `busy` left at 0, when its flag does not allow it or when it arrives while `busy` is 1.
- R10: The two strobes are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_wr | input | 1 | Write request pulse |
| req_rd | input | 1 | Read request pulse |
| wr_byte | input | DATA_W | Byte to send, latched when the write is accepted |
| rd_byte | output | DATA_W | Last byte captured from the device |
| rd_valid | output | 1 | One-cycle pulse marking a new `rd_byte` |
| busy | output | 1 | Transaction in progress (wait-request) |
| tx_room | output | 1 | Synchronised "device can take a byte" |
| rx_avail | output | 1 | Synchronised "device holds a byte" |
| chip_rx_n | input | 1 | Device receive-data flag, active low |
| chip_tx_n | input | 1 | Device transmit-room flag, active low |
| rd_strobe_n | output | 1 | Read strobe to device, active low |
| wr_strobe_n | output | 1 | Write strobe to device, active low |
| pad_dout | output | DATA_W | Byte bus output value |
| pad_oe | output | 1 | Byte bus output enable |
| pad_din | input | DATA_W | Byte bus input value |

## Verification
During a read, the bench changes `pad_din` on every strobe cycle, and only the last value is the true byte. A design that samples early or late therefore captures a wrong byte. During a write, the bench replaces `wr_byte` right after acceptance, which exposes a design that does not latch the byte, and it checks output enable one cycle before and one cycle after the strobe, which catches a bus released too soon. The bench also raises both requests together, raises requests while `busy` is 1, and raises requests while the flag forbids them. A design with the wrong priority would pulse the read strobe. A design that accepts requests outside idle would start a second, phantom transaction. The bench also measures the flag synchroniser latency at the exact cycle, which separates one, two and three stages.

// File: rtl/usb_bridge_pkg.sv
package usb_bridge_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WSETUP,
      ST_WSTRB,
      ST_WHOLD,
      ST_RSTRB,
      ST_GAP
   } seq_state_t;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
   parameter int              WIDTH   = 2,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("flag_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
   import usb_bridge_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int SETUP_CYC  = 1,
   parameter int STROBE_CYC = 3,
   parameter int HOLD_CYC   = 1,
   parameter int GAP_CYC    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wr,
   input  logic              req_rd,
   input  logic              tx_room,
   input  logic              rx_avail,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic [DATA_W-1:0] pad_din,
   output logic              busy,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_byte,
   output logic [DATA_W-1:0] pad_dout,
   output logic              pad_oe,
   output logic              rd_strobe_n,
   output logic              wr_strobe_n
);

   localparam int MAXLEN = max4(SETUP_CYC, STROBE_CYC, HOLD_CYC, GAP_CYC);
   localparam int CNT_W  = $clog2(MAXLEN + 1);
   localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] LD_STROBE = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] LD_GAP    = CNT_W'(GAP_CYC - 1);

   seq_state_t       state, nxt;
   logic [CNT_W-1:0] cnt, nxt_cnt;
   logic             take_wr, take_rd, capture, last_rd;
   logic             cnt_done;

   assign cnt_done = (cnt == '0);

   always_comb begin
      nxt     = state;
      nxt_cnt = cnt_done ? cnt : cnt - 1'b1;
      take_wr = 1'b0;
      take_rd = 1'b0;
      capture = 1'b0;
      unique case (state)
         ST_IDLE: begin
            nxt_cnt = '0;
            if (req_wr && tx_room) begin
               nxt = ST_WSETUP; nxt_cnt = LD_SETUP; take_wr = 1'b1;
            end else if (req_rd && rx_avail) begin
               nxt = ST_RSTRB;  nxt_cnt = LD_STROBE; take_rd = 1'b1;
            end
         end
         ST_WSETUP: if (cnt_done) begin nxt = ST_WSTRB; nxt_cnt = LD_STROBE; end
         ST_WSTRB:  if (cnt_done) begin nxt = ST_WHOLD; nxt_cnt = LD_HOLD;   end
         ST_WHOLD:  if (cnt_done) begin nxt = ST_GAP;   nxt_cnt = LD_GAP;    end
         ST_RSTRB:  if (cnt_done) begin
                       nxt = ST_GAP; nxt_cnt = LD_GAP; capture = 1'b1;
                    end
         ST_GAP:    if (cnt_done) begin nxt = ST_IDLE;  nxt_cnt = '0;        end
         default:   begin nxt = ST_IDLE; nxt_cnt = '0; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         last_rd     <= 1'b0;
         busy        <= 1'b0;
         rd_valid    <= 1'b0;
         rd_byte     <= '0;
         pad_dout    <= '0;
         pad_oe      <= 1'b0;
         rd_strobe_n <= 1'b1;
         wr_strobe_n <= 1'b1;
      end else begin
         state       <= nxt;
         cnt         <= nxt_cnt;
         busy        <= (nxt != ST_IDLE);
         rd_strobe_n <= (nxt != ST_RSTRB);
         wr_strobe_n <= (nxt != ST_WSTRB);
         pad_oe      <= (nxt == ST_WSETUP) || (nxt == ST_WSTRB) || (nxt == ST_WHOLD);
         rd_valid    <= (state == ST_GAP) && (nxt == ST_IDLE) && last_rd;
         if (take_wr) begin
            pad_dout <= wr_byte;
            last_rd  <= 1'b0;
         end
         if (take_rd) last_rd <= 1'b1;
         if (capture) rd_byte <= pad_din;
      end
   end

endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SETUP_CYC   = 1,
   parameter int STROBE_CYC  = 3,
   parameter int HOLD_CYC    = 1,
   parameter int GAP_CYC     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wr,
   input  logic              req_rd,
   input  logic [DATA_W-1:0] wr_byte,
   output logic [DATA_W-1:0] rd_byte,
   output logic              rd_valid,
   output logic              busy,
   output logic              tx_room,
   output logic              rx_avail,
   input  logic              chip_rx_n,
   input  logic              chip_tx_n,
   output logic              rd_strobe_n,
   output logic              wr_strobe_n,
   output logic [DATA_W-1:0] pad_dout,
   output logic              pad_oe,
   input  logic [DATA_W-1:0] pad_din
);

   generate
      if (DATA_W < 1 || SETUP_CYC < 1 || STROBE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_timing
         $error("usb_fifo_bridge: widths and phase lengths must be at least 1");
      end
      if (GAP_CYC < 2) begin : g_bad_gap
         $error("usb_fifo_bridge: recovery gap must be at least 2 cycles");
      end
   endgenerate

   logic [1:0] flags_n_sync;

   flag_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES),
      .RST_VAL(2'b11)
   ) u_flag_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({chip_tx_n, chip_rx_n}),
      .q    (flags_n_sync)
   );

   assign tx_room  = ~flags_n_sync[1];
   assign rx_avail = ~flags_n_sync[0];

   strobe_seq #(
      .DATA_W    (DATA_W),
      .SETUP_CYC (SETUP_CYC),
      .STROBE_CYC(STROBE_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .GAP_CYC   (GAP_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_wr     (req_wr),
      .req_rd     (req_rd),
      .tx_room    (tx_room),
      .rx_avail   (rx_avail),
      .wr_byte    (wr_byte),
      .pad_din    (pad_din),
      .busy       (busy),
      .rd_valid   (rd_valid),
      .rd_byte    (rd_byte),
      .pad_dout   (pad_dout),
      .pad_oe     (pad_oe),
      .rd_strobe_n(rd_strobe_n),
      .wr_strobe_n(wr_strobe_n)
   );

endmodule

// File: rtl/usb_fifo_bridge_chk.sv
module usb_fifo_bridge_chk #(
   parameter int STROBE_CYC = 3
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic rd_valid,
   input logic rd_strobe_n,
   input logic wr_strobe_n,
   input logic pad_oe
);

   localparam int CW = $clog2(STROBE_CYC + 2);

   logic [CW-1:0] low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          low_len <= '0;
      else if (!rd_strobe_n || !wr_strobe_n) low_len <= low_len + 1'b1;
      else                                 low_len <= '0;
   end

   p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_strobe_n && !wr_strobe_n));

   p_busy_in_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_strobe_n || !wr_strobe_n) |-> busy);

   p_oe_with_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_strobe_n |-> pad_oe);

   p_oe_before_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_strobe_n) |-> $past(pad_oe));

   p_oe_after_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_strobe_n) |-> pad_oe);

   p_no_drive_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe_n |-> !pad_oe);

   p_strobe_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_strobe_n) || $rose(wr_strobe_n)) |-> (low_len == CW'(STROBE_CYC)));

   p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !busy);

   p_gap_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_strobe_n) |=> (busy && rd_strobe_n && wr_strobe_n && !pad_oe));

endmodule

bind usb_fifo_bridge usb_fifo_bridge_chk #(
   .STROBE_CYC(STROBE_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .rd_valid   (rd_valid),
   .rd_strobe_n(rd_strobe_n),
   .wr_strobe_n(wr_strobe_n),
   .pad_oe     (pad_oe)
);

// File: tb/usb_fifo_bridge_tb.sv
module usb_fifo_bridge_tb;

   localparam int CLK_PERIOD = 20;
   localparam int SETUP      = 1;
   localparam int STRB       = 3;
   localparam int HOLD       = 1;
   localparam int GAP        = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_wr = 1'b0, req_rd = 1'b0;
   logic [7:0] wr_byte = '0;
   logic [7:0] rd_byte;
   logic       rd_valid, busy, tx_room, rx_avail;
   logic       chip_rx_n = 1'b1, chip_tx_n = 1'b1;
   logic       rd_strobe_n, wr_strobe_n, pad_oe;
   logic [7:0] pad_dout;
   logic [7:0] pad_din = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_fifo_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
      .wr_byte(wr_byte), .rd_byte(rd_byte), .rd_valid(rd_valid), .busy(busy),
      .tx_room(tx_room), .rx_avail(rx_avail), .chip_rx_n(chip_rx_n),
      .chip_tx_n(chip_tx_n), .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
      .pad_dout(pad_dout), .pad_oe(pad_oe), .pad_din(pad_din)
   );

   function automatic logic flag_level(input logic chip_n);
      return ~chip_n;
   endfunction

   function automatic logic [7:0] decoy(input logic [7:0] b, input int k);
      return b ^ 8'(8'h5A + k);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] b, input bit both, input bit poke);
      @(negedge clk);
      req_wr = 1'b1; req_rd = both; wr_byte = b;
      @(negedge clk);
      req_wr = 1'b0; req_rd = 1'b0; wr_byte = ~b;
      for (int s = 0; s < SETUP; s++) begin
         if (s > 0) @(negedge clk);
         chk("R3", "busy in setup", busy, 1);
         chk("R4", "oe in setup", pad_oe, 1);
         chk("R4", "wr strobe in setup", wr_strobe_n, 1);
         chk("R8", "no read strobe", rd_strobe_n, 1);
      end
      for (int p = 0; p < STRB; p++) begin
         @(negedge clk);
         chk("R4", "wr strobe low", wr_strobe_n, 0);
         chk("R4", "byte on bus", pad_dout, b);
         chk("R4", "oe in strobe", pad_oe, 1);
         chk("R10", "rd strobe high", rd_strobe_n, 1);
      end
      for (int h = 0; h < HOLD; h++) begin
         @(negedge clk);
         chk("R4", "hold strobe high", wr_strobe_n, 1);
         chk("R4", "hold oe", pad_oe, 1);
         chk("R4", "hold byte", pad_dout, b);
      end
      for (int g = 0; g < GAP; g++) begin
         @(negedge clk);
         chk("R7", "gap busy", busy, 1);
         chk("R7", "gap strobes", {rd_strobe_n, wr_strobe_n}, 2'b11);
         chk("R7", "gap bus released", pad_oe, 0);
         if (poke) begin req_wr = 1'b1; req_rd = 1'b1; end
      end
      @(negedge clk);
      req_wr = 1'b0; req_rd = 1'b0;
      chk("R3", "busy ends", busy, 0);
      if (poke) begin
         @(negedge clk);
         chk("R9", "busy-time request ignored", busy, 0);
         chk("R9", "no strobe after ignored", {rd_strobe_n, wr_strobe_n}, 2'b11);
      end
   endtask

   task automatic do_read(input logic [7:0] b);
      @(negedge clk);
      req_rd = 1'b1;
      @(negedge clk);
      req_rd = 1'b0;
      for (int p = 0; p < STRB; p++) begin
         if (p > 0) @(negedge clk);
         pad_din = (p == STRB - 1) ? b : decoy(b, p);
         chk("R5", "rd strobe low", rd_strobe_n, 0);
         chk("R5", "bus not driven", pad_oe, 0);
         chk("R10", "wr strobe high", wr_strobe_n, 1);
      end
      for (int g = 0; g < GAP; g++) begin
         @(negedge clk);
         pad_din = decoy(b, 7 + g);
         chk("R7", "read gap busy", busy, 1);
         chk("R7", "read gap strobes", {rd_strobe_n, wr_strobe_n}, 2'b11);
         chk("R6", "no early valid", rd_valid, 0);
      end
      @(negedge clk);
      chk("R6", "valid pulse", rd_valid, 1);
      chk("R6", "busy low with valid", busy, 0);
      chk("R5", "captured byte", rd_byte, b);
      @(negedge clk);
      chk("R6", "valid one cycle", rd_valid, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1", "reset busy", busy, 0);
      chk("R1", "reset valid", rd_valid, 0);
      chk("R1", "reset strobes", {rd_strobe_n, wr_strobe_n}, 2'b11);
      chk("R1", "reset oe", pad_oe, 0);
      rst_n = 1'b1;

      // R2: latency of exactly two edges
      @(negedge clk);
      chip_tx_n = 1'b0;
      @(negedge clk);
      chk("R2", "tx flag after 1 edge", tx_room, flag_level(1'b1));
      @(negedge clk);
      chk("R2", "tx flag after 2 edges", tx_room, flag_level(1'b0));
      chk("R2", "rx flag idle", rx_avail, flag_level(1'b1));

      // R9: read with no received data
      @(negedge clk);
      req_rd = 1'b1;
      @(negedge clk);
      req_rd = 1'b0;
      chk("R9", "read w/o data busy", busy, 0);
      chk("R9", "read w/o data strobe", rd_strobe_n, 1);

      chip_rx_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R2", "rx flag after 2 edges", rx_avail, flag_level(1'b0));

      do_write(8'hA5, 1'b0, 1'b0);
      do_read(8'h3C);
      do_write(8'h81, 1'b1, 1'b0);   // R8: both requested
      do_write(8'h00, 1'b0, 1'b1);   // R9: requests while busy
      do_read(8'hFF);

      // R9: write with no transmit room
      chip_tx_n = 1'b1;
      repeat (3) @(negedge clk);
      req_wr = 1'b1; wr_byte = 8'h77;
      @(negedge clk);
      req_wr = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk("R9", "blocked write busy", busy, 0);
         chk("R9", "blocked write oe", pad_oe, 0);
         chk("R9", "blocked write strobe", wr_strobe_n, 1);
         @(negedge clk);
      end
      chip_tx_n = 1'b0;
      repeat (2) @(negedge clk);

      for (int n = 0; n < 40; n++) begin
         int unsigned op;
         logic [7:0] b;
         op = $urandom % 3;
         b  = 8'($urandom);
         case (op)
            0: do_write(b, 1'b0, ($urandom % 4) == 0);
            1: do_read(b);
            default: do_write(b, 1'b1, 1'b0);
         endcase
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule